// File: doc/BRIEF.md
# Dual-Channel Latched Converter Write Interface

This block models, in one clock domain, the digital front end of a dual 8-bit converter. A single shared data port feeds two code latches, one for channel A and one for channel B. A select line chooses the target channel. An active-low chip select and an active-low write strobe open the target latch. While both strobes are low, the selected latch is transparent. The first strobe to rise freezes the latch. The stored codes go out on two registered buses. Each code N stands for a unipolar output of N/256 of the reference: 0 gives zero, and 255 gives full scale less one LSB.

A timing monitor watches every write cycle. It compares the setup, hold and pulse-width intervals against minimum times. A mode input picks one of two timing sets, and a clock-period parameter turns each time into a cycle count. Any rule that fails sets its own sticky flag. The flag stays set until a synchronous clear or a reset. The control inputs and the mode pass through a two-flop synchronizer, and the data port goes through the same two stages so that it stays aligned with them.

Top module: `dual_code_latch`

## Requirements
- R1: A synchronous active-high reset sets both codes to 0 and all violation flags to 0.
- R2: With `sel_i`=0 and both `cs_n_i` and `wr_n_i` low, `code_a_o` follows `data_i` three clock edges after the inputs change, and `code_b_o` does not change.
- R3: With `sel_i`=1 and both strobes low, `code_b_o` follows `data_i` with the same latency, and `code_a_o` does not change.
- R4: While `cs_n_i` or `wr_n_i` is high, neither code changes, whatever `sel_i` and `data_i` do.
- R5: When a write ends, the selected code keeps the data sampled in the last cycle before the first strobe rose. Data that changes after that has no effect.
- R6: Flag bit 6 (pulse width) is set when both strobes were low together for fewer than ceil(Tpw/CLK_NS) cycles.
- R7: Flag bit 0 (chip-select setup) is set when chip select was low for fewer than ceil(Tcs_su/CLK_NS) cycles before the write ended. Flag bit 1 (chip-select hold) is set when chip select goes high within ceil(Tcs_hd/CLK_NS) cycles of the end, counting the end cycle.
- R8: Flag bit 2 (select setup) is set when the select level was stable for fewer than ceil(Tsel_su/CLK_NS) cycles before the end. Flag bit 3 (select hold) is set when the select level changes inside its hold window.
- R9: Flag bit 4 (data setup) is set when data was stable for fewer than ceil(Tdat_su/CLK_NS) cycles before the end. Flag bit 5 (data hold) applies the data hold window.
- R10: `fast_i`=0 selects the times cs setup 90, cs hold 0, select setup 90, select hold 0, data setup 80, data hold 0 and pulse 90 ns. `fast_i`=1 selects 60, 10, 60, 10, 30, 0 and 60 ns. An interval exactly at its minimum is legal.
- R11: The flags are sticky. `viol_clr_i` high clears all of them at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, period CLK_NS |
| rst | input | 1 | Synchronous active-high reset |
| cs_n_i | input | 1 | Active-low chip select |
| wr_n_i | input | 1 | Active-low write strobe |
| sel_i | input | 1 | Channel select: 0 = A, 1 = B |
| data_i | input | DW | Shared data port, bit DW-1 is the MSB |
| fast_i | input | 1 | Timing set: 0 = slow limits, 1 = fast limits |
| viol_clr_i | input | 1 | Synchronous clear of all violation flags |
| code_a_o | output | DW | Stored code of channel A |
| code_b_o | output | DW | Stored code of channel B |
| viol_o | output | 7 | Sticky violation flags, bit order as in R6 to R9 |

## Verification
The bench builds write cycles with the lead, pulse and tail lengths set one cycle at a time. It places each interval exactly at its limit and one cycle short, in both timing sets. An off-by-one counter would flag the legal edge or miss the short one. A select line that changes while the strobes are low has to write the other channel with the data of that moment; a design that latched the channel only at the end would leave the other code stale. Cycles in which chip select rises before the write strobe, followed by data changes, catch a latch that still listens to the write strobe alone. They also catch a hold check that only watches the write strobe.

// File: rtl/dcl_pkg.sv
package dcl_pkg;
  localparam int NRULES   = 7;
  localparam int RB_CS_SU  = 0;
  localparam int RB_CS_HD  = 1;
  localparam int RB_SEL_SU = 2;
  localparam int RB_SEL_HD = 3;
  localparam int RB_DAT_SU = 4;
  localparam int RB_DAT_HD = 5;
  localparam int RB_PULSE  = 6;

  // smallest cycle count whose duration covers the given time
  function automatic int ns2cyc(input int ns, input int clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction
endpackage

// File: rtl/dcl_sync.sv
module dcl_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/dcl_run_count.sv
// Length of the run of equal samples that ends in the previous cycle.
module dcl_run_count #(
  parameter int W  = 1,
  parameter int CW = 4,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [W-1:0]  cur,
  output logic [W-1:0]  prev,
  output logic [CW-1:0] run
);
  always_ff @(posedge clk) begin
    if (rst) begin
      prev <= RST_VAL;
      run  <= '0;
    end else begin
      prev <= cur;
      if (cur != prev)
        run <= CW'(1);
      else if (run != '1)
        run <= run + 1'b1;
    end
  end
endmodule

// File: rtl/dcl_hold_guard.sv
// After an end event, the watched value must equal the last value sampled
// before the event for `limit` samples, the event cycle included.
module dcl_hold_guard #(
  parameter int W  = 1,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          evt,
  input  logic [CW-1:0] limit,
  input  logic [W-1:0]  cur,
  input  logic [W-1:0]  prev,
  output logic          bad
);
  logic [W-1:0]  ref_q;
  logic [CW-1:0] left;

  always_comb begin
    if (evt)
      bad = (limit != '0) && (cur != prev);
    else
      bad = (left != '0) && (cur != ref_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_q <= '0;
      left  <= '0;
    end else if (evt) begin
      ref_q <= prev;
      left  <= (limit == '0) ? '0 : limit - 1'b1;
    end else if (left != '0) begin
      left <= left - 1'b1;
    end
  end
endmodule

// File: rtl/dcl_timing_mon.sv
module dcl_timing_mon
  import dcl_pkg::*;
#(
  parameter int DW             = 8,
  parameter int CLK_NS         = 10,
  parameter int SLOW_CS_SU_NS  = 90,
  parameter int SLOW_CS_HD_NS  = 0,
  parameter int SLOW_SEL_SU_NS = 90,
  parameter int SLOW_SEL_HD_NS = 0,
  parameter int SLOW_DAT_SU_NS = 80,
  parameter int SLOW_DAT_HD_NS = 0,
  parameter int SLOW_PW_NS     = 90,
  parameter int FAST_CS_SU_NS  = 60,
  parameter int FAST_CS_HD_NS  = 10,
  parameter int FAST_SEL_SU_NS = 60,
  parameter int FAST_SEL_HD_NS = 10,
  parameter int FAST_DAT_SU_NS = 30,
  parameter int FAST_DAT_HD_NS = 0,
  parameter int FAST_PW_NS     = 60
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              fast,
  input  logic              cs_n,
  input  logic              wr_n,
  input  logic              sel,
  input  logic [DW-1:0]     data,
  output logic [NRULES-1:0] viol
);
  localparam int SUM_NS = SLOW_CS_SU_NS + SLOW_CS_HD_NS + SLOW_SEL_SU_NS + SLOW_SEL_HD_NS
                        + SLOW_DAT_SU_NS + SLOW_DAT_HD_NS + SLOW_PW_NS
                        + FAST_CS_SU_NS + FAST_CS_HD_NS + FAST_SEL_SU_NS + FAST_SEL_HD_NS
                        + FAST_DAT_SU_NS + FAST_DAT_HD_NS + FAST_PW_NS;
  localparam int CW = $clog2(ns2cyc(SUM_NS, CLK_NS) + 2) + 1;

  localparam logic [CW-1:0] S_CS_SU  = CW'(ns2cyc(SLOW_CS_SU_NS,  CLK_NS));
  localparam logic [CW-1:0] S_CS_HD  = CW'(ns2cyc(SLOW_CS_HD_NS,  CLK_NS));
  localparam logic [CW-1:0] S_SEL_SU = CW'(ns2cyc(SLOW_SEL_SU_NS, CLK_NS));
  localparam logic [CW-1:0] S_SEL_HD = CW'(ns2cyc(SLOW_SEL_HD_NS, CLK_NS));
  localparam logic [CW-1:0] S_DAT_SU = CW'(ns2cyc(SLOW_DAT_SU_NS, CLK_NS));
  localparam logic [CW-1:0] S_DAT_HD = CW'(ns2cyc(SLOW_DAT_HD_NS, CLK_NS));
  localparam logic [CW-1:0] S_PW     = CW'(ns2cyc(SLOW_PW_NS,     CLK_NS));
  localparam logic [CW-1:0] F_CS_SU  = CW'(ns2cyc(FAST_CS_SU_NS,  CLK_NS));
  localparam logic [CW-1:0] F_CS_HD  = CW'(ns2cyc(FAST_CS_HD_NS,  CLK_NS));
  localparam logic [CW-1:0] F_SEL_SU = CW'(ns2cyc(FAST_SEL_SU_NS, CLK_NS));
  localparam logic [CW-1:0] F_SEL_HD = CW'(ns2cyc(FAST_SEL_HD_NS, CLK_NS));
  localparam logic [CW-1:0] F_DAT_SU = CW'(ns2cyc(FAST_DAT_SU_NS, CLK_NS));
  localparam logic [CW-1:0] F_DAT_HD = CW'(ns2cyc(FAST_DAT_HD_NS, CLK_NS));
  localparam logic [CW-1:0] F_PW     = CW'(ns2cyc(FAST_PW_NS,     CLK_NS));

  logic [CW-1:0] lim_cs_su, lim_cs_hd, lim_sel_su, lim_sel_hd;
  logic [CW-1:0] lim_dat_su, lim_dat_hd, lim_pw;

  always_comb begin
    lim_cs_su  = fast ? F_CS_SU  : S_CS_SU;
    lim_cs_hd  = fast ? F_CS_HD  : S_CS_HD;
    lim_sel_su = fast ? F_SEL_SU : S_SEL_SU;
    lim_sel_hd = fast ? F_SEL_HD : S_SEL_HD;
    lim_dat_su = fast ? F_DAT_SU : S_DAT_SU;
    lim_dat_hd = fast ? F_DAT_HD : S_DAT_HD;
    lim_pw     = fast ? F_PW     : S_PW;
  end

  logic          act, act_prev, cs_prev, sel_prev, end_evt;
  logic [DW-1:0] dat_prev;
  logic [CW-1:0] act_run, cs_run, sel_run, dat_run;

  assign act     = !cs_n && !wr_n;
  assign end_evt = act_prev && !act;

  dcl_run_count #(.W(1), .CW(CW), .RST_VAL(1'b0)) u_run_act (
    .clk(clk), .rst(rst), .cur(act), .prev(act_prev), .run(act_run));
  dcl_run_count #(.W(1), .CW(CW), .RST_VAL(1'b1)) u_run_cs (
    .clk(clk), .rst(rst), .cur(cs_n), .prev(cs_prev), .run(cs_run));
  dcl_run_count #(.W(1), .CW(CW), .RST_VAL(1'b0)) u_run_sel (
    .clk(clk), .rst(rst), .cur(sel), .prev(sel_prev), .run(sel_run));
  dcl_run_count #(.W(DW), .CW(CW), .RST_VAL('0)) u_run_dat (
    .clk(clk), .rst(rst), .cur(data), .prev(dat_prev), .run(dat_run));

  logic bad_cs_hd, bad_sel_hd, bad_dat_hd;

  dcl_hold_guard #(.W(1), .CW(CW)) u_hold_cs (
    .clk(clk), .rst(rst), .evt(end_evt), .limit(lim_cs_hd),
    .cur(cs_n), .prev(cs_prev), .bad(bad_cs_hd));
  dcl_hold_guard #(.W(1), .CW(CW)) u_hold_sel (
    .clk(clk), .rst(rst), .evt(end_evt), .limit(lim_sel_hd),
    .cur(sel), .prev(sel_prev), .bad(bad_sel_hd));
  dcl_hold_guard #(.W(DW), .CW(CW)) u_hold_dat (
    .clk(clk), .rst(rst), .evt(end_evt), .limit(lim_dat_hd),
    .cur(data), .prev(dat_prev), .bad(bad_dat_hd));

  logic [NRULES-1:0] bad;

  always_comb begin
    bad            = '0;
    bad[RB_CS_SU]  = end_evt && (cs_run  < lim_cs_su);
    bad[RB_SEL_SU] = end_evt && (sel_run < lim_sel_su);
    bad[RB_DAT_SU] = end_evt && (dat_run < lim_dat_su);
    bad[RB_PULSE]  = end_evt && (act_run < lim_pw);
    bad[RB_CS_HD]  = bad_cs_hd;
    bad[RB_SEL_HD] = bad_sel_hd;
    bad[RB_DAT_HD] = bad_dat_hd;
  end

  always_ff @(posedge clk) begin
    if (rst || clr)
      viol <= '0;
    else
      viol <= viol | bad;
  end
endmodule

// File: rtl/dual_code_latch.sv
module dual_code_latch
  import dcl_pkg::*;
#(
  parameter int DW             = 8,
  parameter int CLK_NS         = 10,
  parameter int SLOW_CS_SU_NS  = 90,
  parameter int SLOW_CS_HD_NS  = 0,
  parameter int SLOW_SEL_SU_NS = 90,
  parameter int SLOW_SEL_HD_NS = 0,
  parameter int SLOW_DAT_SU_NS = 80,
  parameter int SLOW_DAT_HD_NS = 0,
  parameter int SLOW_PW_NS     = 90,
  parameter int FAST_CS_SU_NS  = 60,
  parameter int FAST_CS_HD_NS  = 10,
  parameter int FAST_SEL_SU_NS = 60,
  parameter int FAST_SEL_HD_NS = 10,
  parameter int FAST_DAT_SU_NS = 30,
  parameter int FAST_DAT_HD_NS = 0,
  parameter int FAST_PW_NS     = 60
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n_i,
  input  logic              wr_n_i,
  input  logic              sel_i,
  input  logic [DW-1:0]     data_i,
  input  logic              fast_i,
  input  logic              viol_clr_i,
  output logic [DW-1:0]     code_a_o,
  output logic [DW-1:0]     code_b_o,
  output logic [NRULES-1:0] viol_o
);
  localparam int SW = DW + 4;
  localparam logic [SW-1:0] SYNC_RST = {1'b0, 1'b0, 1'b1, 1'b1, {DW{1'b0}}};

  logic          fast_s, sel_s, cs_s, wr_s, act_s;
  logic [DW-1:0] data_s;

  // controls are synchronized; data rides the same two stages to stay aligned
  dcl_sync #(.W(SW), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst(rst),
    .d({fast_i, sel_i, cs_n_i, wr_n_i, data_i}),
    .q({fast_s, sel_s, cs_s, wr_s, data_s}));

  assign act_s = !cs_s && !wr_s;

  logic [DW-1:0] code_q [2];

  for (genvar ch = 0; ch < 2; ch++) begin : g_chan
    always_ff @(posedge clk) begin
      if (rst)
        code_q[ch] <= '0;
      else if (act_s && (sel_s == 1'(ch)))
        code_q[ch] <= data_s;
    end
  end

  assign code_a_o = code_q[0];
  assign code_b_o = code_q[1];

  dcl_timing_mon #(
    .DW(DW), .CLK_NS(CLK_NS),
    .SLOW_CS_SU_NS(SLOW_CS_SU_NS), .SLOW_CS_HD_NS(SLOW_CS_HD_NS),
    .SLOW_SEL_SU_NS(SLOW_SEL_SU_NS), .SLOW_SEL_HD_NS(SLOW_SEL_HD_NS),
    .SLOW_DAT_SU_NS(SLOW_DAT_SU_NS), .SLOW_DAT_HD_NS(SLOW_DAT_HD_NS),
    .SLOW_PW_NS(SLOW_PW_NS),
    .FAST_CS_SU_NS(FAST_CS_SU_NS), .FAST_CS_HD_NS(FAST_CS_HD_NS),
    .FAST_SEL_SU_NS(FAST_SEL_SU_NS), .FAST_SEL_HD_NS(FAST_SEL_HD_NS),
    .FAST_DAT_SU_NS(FAST_DAT_SU_NS), .FAST_DAT_HD_NS(FAST_DAT_HD_NS),
    .FAST_PW_NS(FAST_PW_NS)
  ) u_mon (
    .clk(clk), .rst(rst), .clr(viol_clr_i), .fast(fast_s),
    .cs_n(cs_s), .wr_n(wr_s), .sel(sel_s), .data(data_s),
    .viol(viol_o));
endmodule

// File: rtl/dual_code_latch_chk.sv
module dual_code_latch_chk #(
  parameter int DW = 8,
  parameter int NR = 7
) (
  input logic          clk,
  input logic          rst,
  input logic          act_s,
  input logic          sel_s,
  input logic [DW-1:0] data_s,
  input logic          viol_clr_i,
  input logic [DW-1:0] code_a_o,
  input logic [DW-1:0] code_b_o,
  input logic [NR-1:0] viol_o
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (code_a_o == '0) && (code_b_o == '0) && (viol_o == '0));

  // R2
  follow_a_chk: assert property (@(posedge clk) disable iff (rst)
    (act_s && !sel_s) |=> (code_a_o == $past(data_s)) && $stable(code_b_o));

  // R3
  follow_b_chk: assert property (@(posedge clk) disable iff (rst)
    (act_s && sel_s) |=> (code_b_o == $past(data_s)) && $stable(code_a_o));

  // R4
  hold_both_chk: assert property (@(posedge clk) disable iff (rst)
    !act_s |=> $stable(code_a_o) && $stable(code_b_o));

  // R11
  sticky_flags_chk: assert property (@(posedge clk) disable iff (rst)
    !viol_clr_i |=> ((viol_o & $past(viol_o)) == $past(viol_o)));

  // R11
  clear_flags_chk: assert property (@(posedge clk) disable iff (rst)
    viol_clr_i |=> (viol_o == '0));
endmodule

bind dual_code_latch dual_code_latch_chk #(.DW(DW), .NR(dcl_pkg::NRULES)) u_chk (
  .clk(clk), .rst(rst), .act_s(act_s), .sel_s(sel_s), .data_s(data_s),
  .viol_clr_i(viol_clr_i), .code_a_o(code_a_o), .code_b_o(code_b_o),
  .viol_o(viol_o));

// File: tb/dual_code_latch_test.sv
module dual_code_latch_test;
  localparam int CLK_PERIOD = 10;
  localparam int F = 20;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs_n = 1'b1, wr_n = 1'b1, sel = 1'b0, fast = 1'b0, clr = 1'b0;
  logic [7:0] data = '0;
  logic [7:0] code_a, code_b;
  logic [6:0] viol;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] exp_a = '0, exp_b = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_code_latch uut (
    .clk(clk), .rst(rst), .cs_n_i(cs_n), .wr_n_i(wr_n), .sel_i(sel),
    .data_i(data), .fast_i(fast), .viol_clr_i(clr),
    .code_a_o(code_a), .code_b_o(code_b), .viol_o(viol));

  // timing limits in cycles, from the times listed in R10
  function automatic int cyc(input int ns);
    return (ns + CLK_PERIOD - 1) / CLK_PERIOD;
  endfunction
  function automatic int lim(input int rule, input logic fm);
    int s [7] = '{90, 0, 90, 0, 80, 0, 90};
    int f [7] = '{60, 10, 60, 10, 30, 0, 60};
    return fm ? cyc(f[rule]) : cyc(s[rule]);
  endfunction

  function automatic logic [6:0] exp_flags(input int pw, csl, sll, dl, csh, slh, dh,
                                           input logic csf, input logic fm);
    logic [6:0] e;
    e[0] = (pw + csl) < lim(0, fm);
    e[1] = csf ? (lim(1, fm) > 0) : (csh < lim(1, fm));
    e[2] = sll < lim(2, fm);
    e[3] = slh < lim(3, fm);
    e[4] = dl < lim(4, fm);
    e[5] = dh < lim(5, fm);
    e[6] = pw < lim(6, fm);
    return e;
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%0h expected=%0h", req, got, exp);
    end
  endtask

  function automatic int rr(input int lo, input int hi);
    return lo + int'($urandom % (hi - lo + 1));
  endfunction

  // One write cycle; t = 0 is the first cycle after the first strobe rises.
  task automatic run_frame(input logic s, input logic [7:0] d, input int pw, csl, sll, dl,
                           csh, slh, dh, input logic csf, input int wtail, input logic fm);
    logic [6:0] ef;
    @(negedge clk);
    clr = 1'b1; fast = fm; sel = ~s; data = ~d; cs_n = 1'b1; wr_n = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    for (int k = 0; k < F + 12; k++) begin
      int t;
      t = k - F;
      wr_n = !(t >= -pw && t < (csf ? wtail : 0));
      cs_n = !(t >= -pw - csl && t < (csf ? 0 : csh));
      sel  = (t >= -sll && t < slh) ? s : ~s;
      data = (t >= -dl && t < dh) ? d : ~d;
      @(negedge clk);
    end
    repeat (4) @(negedge clk);
    // the other channel is written if select switched while the strobes were low
    if (sll < pw) begin
      if (s) exp_a = (sll + 1 <= dl) ? d : ~d;
      else   exp_b = (sll + 1 <= dl) ? d : ~d;
    end
    if (s) exp_b = d; else exp_a = d;
    ef = exp_flags(pw, csl, sll, dl, csh, slh, dh, csf, fm);
    chk(s ? "R3 R5 code B" : "R2 R5 code A", s ? code_b : code_a, s ? exp_b : exp_a);
    chk(s ? "R2 other code A" : "R3 other code B", s ? code_a : code_b, s ? exp_a : exp_b);
    chk("R6 R7 R8 R9 R10 flags", viol, ef);
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset code A", code_a, 0);
    chk("R1 reset code B", code_b, 0);
    chk("R1 reset flags", viol, 0);

    // exact limits, slow set: nothing flagged (R10)
    run_frame(0, 8'hA5, 9, 0, 9, 8, 0, 5, 0, 0, 0, 0);
    // pulse one cycle short (R6)
    run_frame(1, 8'h3C, 8, 1, 8, 8, 0, 5, 0, 0, 0, 0);
    // fast set exact limits (R10), cs hold 1 cycle met
    run_frame(0, 8'hFF, 6, 0, 6, 3, 1, 1, 0, 0, 0, 1);
    // fast: cs and wr rise together -> cs hold (R7); select hold short (R8)
    run_frame(1, 8'h00, 6, 0, 6, 3, 0, 0, 0, 0, 0, 1);
    // chip select rises first, write stays low, data changes after (R5, R7)
    run_frame(0, 8'h5A, 10, 0, 10, 10, 0, 4, 0, 1, 3, 1);
    run_frame(1, 8'h81, 10, 0, 10, 10, 0, 4, 0, 1, 3, 0);
    // select switches mid-write, data short setup (R8, R9)
    run_frame(1, 8'h7E, 12, 0, 4, 2, 1, 2, 1, 0, 0, 0);

    // sticky and clear (R11): make a violation, wait, then clear
    run_frame(0, 8'h11, 2, 0, 2, 2, 0, 5, 0, 0, 0, 1);
    repeat (10) @(negedge clk);
    chk("R11 sticky", viol, exp_flags(2, 0, 2, 2, 0, 5, 0, 0, 1));
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    chk("R11 clear", viol, 0);

    // transparency while both strobes low (R2)
    fast = 1'b0; sel = 1'b0; data = 8'h12; cs_n = 1'b0; wr_n = 1'b0;
    repeat (5) @(negedge clk);
    chk("R2 transparent first", code_a, 8'h12);
    data = 8'hED;
    repeat (4) @(negedge clk);
    chk("R2 transparent follow", code_a, 8'hED);
    chk("R2 B untouched", code_b, exp_b);
    exp_a = 8'hED;
    cs_n = 1'b1; wr_n = 1'b1;
    repeat (5) @(negedge clk);

    // strobes not both low: nothing changes (R4)
    for (int k = 0; k < 12; k++) begin
      cs_n = (k < 6); wr_n = (k >= 6) ? 1'b1 : logic'($urandom % 2);
      sel = logic'($urandom % 2); data = 8'($urandom);
      @(negedge clk);
    end
    cs_n = 1'b1; wr_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R4 code A held", code_a, exp_a);
    chk("R4 code B held", code_b, exp_b);

    // random write cycles
    for (int n = 0; n < 80; n++) begin
      logic csf;
      csf = ($urandom % 8) == 0;
      run_frame(logic'($urandom % 2), 8'($urandom), rr(1, 12), rr(0, 6), rr(1, 16),
                rr(1, 16), rr(0, 3), rr(0, 3), rr(0, 2), csf, rr(1, 3),
                logic'($urandom % 2));
    end

    // reset in mid-run (R1)
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1 reset code A again", code_a, 0);
    chk("R1 reset code B again", code_b, 0);
    chk("R1 reset flags again", viol, 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    done = 1;
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired got=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule